// File: doc/BRIEF.md
# Sum-of-products macrocell with configurable storage element

This block models one cell of a sum-of-products programmable logic array in ordinary synchronous logic. An AND array forms nine product terms over a fixed input bus. Each term's literals are chosen by a pair of static masks. Three of the terms are ORed together and passed through a two-input XOR whose other input is a fourth term. That term gives either polarity inversion or an arithmetic-style XOR. The XOR result drives a storage element. Static configuration makes that element a D, T, JK or SR flip-flop, a transparent latch, or a plain combinational pass-through.

The remaining terms each have one job: the K/R input, the pin output enable, asynchronous preset, asynchronous clear and an array clock. The emulated clock is either a global clock input, which acts on rising edges only, or the array-clock term, whose active edge is selectable. All of this runs on one fast system clock. Emulated clocks are sampled, and their edges and levels are detected. Preset and clear act on the next system clock without waiting for an emulated clock edge. The cell has two feedback outputs that are independent of each other. The cell feedback always carries the stored value. The pin feedback carries the pin's value, which comes from outside when the output enable is off.

Top module: `plm_macrocell`

## Requirements
- R1: Product term t (0..8) uses bits [t*N_IN +: N_IN] of `cfg_true_mask` and `cfg_comp_mask`. The term is 1 when every input whose true-mask bit is set is 1 and every input whose complement-mask bit is set is 0; a term with no mask bits set is 1. The term roles are: 0, 1 and 2 are sum terms, 3 is the XOR term, 4 is K/R, 5 is output enable, 6 is preset, 7 is clear and 8 is the array clock.
- R2: The storage data value is (term0 | term1 | term2) XOR term3.
- R3: Mode encoding is 0 = D, 1 = T, 2 = JK, 3 = SR, 4 = latch and 5 = bypass; codes 6 and 7 behave as D. In bypass the stored value follows the data value every system cycle, and preset and clear are ignored.
- R4: In D mode the state takes the data value on an active clock edge and holds otherwise.
- R5: In T mode the state inverts on an active clock edge when the data value is 1.
- R6: In JK mode the data value is J and term 4 is K. On an edge, J=K=1 toggles the state, J alone sets it, K alone clears it, and neither holds it.
- R7: In SR mode the data value is S and term 4 is R. On an edge, S alone sets the state, R alone clears it, and S=R=1 or neither holds it.
- R8: In latch mode the state follows the data value while the clock level is active and holds otherwise. The active level is high for the global clock and for a rising-edge array clock, and low for a falling-edge array clock.
- R9: In every mode except bypass, preset (term 6) sets the state and clear (term 7) clears it, whatever the clock is doing. When both are asserted, clear wins.
- R10: With `cfg_clk_sel`=0 the clock is `gclk_in` and its rising edge is active. With `cfg_clk_sel`=1 the clock is term 8; its rising edge is active when `cfg_clk_fall`=0 and its falling edge when `cfg_clk_fall`=1.
- R11: `pin_oe` equals term 5. `pin_drive` and `mc_fb` both equal the state whatever the value of `pin_oe`.
- R12: `pin_fb` equals `pin_drive` while `pin_oe` is 1 and equals the external `pin_in` otherwise.
- R13: Inputs are registered on each system clock and the outputs change two clocks later. Synchronous reset clears the state, the clock history, the input registers and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gclk_in | input | 1 | Emulated global clock (sampled) |
| in_bus | input | N_IN | Input bus feeding the AND array |
| pin_in | input | 1 | Externally driven pin value |
| cfg_true_mask | input | 9*N_IN | True-literal selection for each product term |
| cfg_comp_mask | input | 9*N_IN | Complement-literal selection for each product term |
| cfg_mode | input | 3 | Storage element mode |
| cfg_clk_sel | input | 1 | 0 = global clock, 1 = array-clock term |
| cfg_clk_fall | input | 1 | Falling active edge for the array clock |
| pin_drive | output | 1 | Value offered to the pin buffer |
| pin_oe | output | 1 | Pin buffer enable, active high |
| mc_fb | output | 1 | Cell feedback (stored value) |
| pin_fb | output | 1 | Pin feedback |

## Verification
Each of the six modes is run under three clocking choices: the global clock, a rising array clock and a falling array clock. Every run uses pseudo-random input vectors and randomly drawn one- to three-literal masks. Under these patterns, edge-triggered updates, level-transparent updates and holds produce different traces, and the falling-edge runs show whether the edge polarity is applied. A run with frequent preset and clear terms separates clear priority from preset. A run with an empty XOR term shows the constant-one term rule and inversion through the XOR. Pin feedback is compared in every cycle, both with the enable on and with it off, so the external pin value and the driven value are told apart.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int PT_COUNT = 9;
  localparam int PT_SUM0  = 0;
  localparam int PT_XOR   = 3;
  localparam int PT_KR    = 4;
  localparam int PT_OE    = 5;
  localparam int PT_PRE   = 6;
  localparam int PT_CLR   = 7;
  localparam int PT_CLK   = 8;

  typedef enum logic [2:0] {
    MODE_D      = 3'd0,
    MODE_T      = 3'd1,
    MODE_JK     = 3'd2,
    MODE_SR     = 3'd3,
    MODE_LATCH  = 3'd4,
    MODE_BYPASS = 3'd5
  } plm_mode_e;
endpackage

// File: rtl/plm_and_array.sv
module plm_and_array #(
  parameter int N_IN    = 8,
  parameter int N_TERMS = 9
) (
  input  logic [N_IN-1:0]         lits,
  input  logic [N_TERMS*N_IN-1:0] true_mask,
  input  logic [N_TERMS*N_IN-1:0] comp_mask,
  output logic [N_TERMS-1:0]      terms
);
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [N_IN-1:0] tm, cm;
    assign tm = true_mask[t*N_IN +: N_IN];
    assign cm = comp_mask[t*N_IN +: N_IN];
    // every selected literal must be satisfied; no selection gives 1
    assign terms[t] = &((~tm | lits) & (~cm | ~lits));
  end
endmodule

// File: rtl/plm_clock_sel.sv
module plm_clock_sel (
  input  logic clk,
  input  logic rst,
  input  logic gclk_s,
  input  logic pt_clk,
  input  logic use_pt,
  input  logic fall,
  output logic clk_edge,
  output logic clk_level
);
  logic src, prev, inv;

  assign src = use_pt ? pt_clk : gclk_s;
  assign inv = use_pt & fall;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= src;
  end

  assign clk_level = inv ? ~src : src;
  assign clk_edge  = inv ? (prev & ~src) : (src & ~prev);

  // R10: an active edge always lands on the active level
  a_r10_edge_on_level: assert property (@(posedge clk) disable iff (rst)
    clk_edge |-> clk_level);
endmodule

// File: rtl/plm_storage.sv
module plm_storage
  import plm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  plm_mode_e mode,
  input  logic      din,
  input  logic      kr,
  input  logic      pre,
  input  logic      clr,
  input  logic      clk_edge,
  input  logic      clk_level,
  output logic      st
);
  logic nxt;

  always_comb begin
    nxt = st;
    if (mode == MODE_BYPASS) begin
      nxt = din;
    end else if (clr) begin
      nxt = 1'b0;
    end else if (pre) begin
      nxt = 1'b1;
    end else if (mode == MODE_LATCH) begin
      if (clk_level) nxt = din;
    end else if (clk_edge) begin
      case (mode)
        MODE_T:  nxt = st ^ din;
        MODE_JK: nxt = (din & kr) ? ~st : (din ? 1'b1 : (kr ? 1'b0 : st));
        MODE_SR: nxt = (din & kr) ? st  : (din ? 1'b1 : (kr ? 1'b0 : st));
        default: nxt = din;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= 1'b0;
    else     st <= nxt;
  end

  // R9: clear dominates preset outside bypass
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr && mode != MODE_BYPASS) |=> (st == 1'b0));
  // R9: preset alone sets the state
  a_r9_preset_sets: assert property (@(posedge clk) disable iff (rst)
    (pre && !clr && mode != MODE_BYPASS) |=> (st == 1'b1));
  // R3: bypass tracks the data value
  a_r3_bypass_follows: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BYPASS) |=> (st == $past(din)));
  // R4: D register holds without an edge
  a_r4_d_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_D && !clk_edge && !pre && !clr) |=> $stable(st));
  // R8: latch opaque outside the active level
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH && !clk_level && !pre && !clr) |=> $stable(st));
endmodule

// File: rtl/plm_macrocell.sv
module plm_macrocell
  import plm_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     gclk_in,
  input  logic [N_IN-1:0]          in_bus,
  input  logic                     pin_in,
  input  logic [PT_COUNT*N_IN-1:0] cfg_true_mask,
  input  logic [PT_COUNT*N_IN-1:0] cfg_comp_mask,
  input  logic [2:0]               cfg_mode,
  input  logic                     cfg_clk_sel,
  input  logic                     cfg_clk_fall,
  output logic                     pin_drive,
  output logic                     pin_oe,
  output logic                     mc_fb,
  output logic                     pin_fb
);
  logic [N_IN-1:0]     in_q;
  logic                gclk_q, pin_in_q, pin_in_d, oe_d;
  logic [PT_COUNT-1:0] pt;
  logic                sum_or, data_x, edge_w, level_w, state;

  // input sampling stage
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q     <= '0;
      gclk_q   <= 1'b0;
      pin_in_q <= 1'b0;
    end else begin
      in_q     <= in_bus;
      gclk_q   <= gclk_in;
      pin_in_q <= pin_in;
    end
  end

  plm_and_array #(.N_IN(N_IN), .N_TERMS(PT_COUNT)) u_array (
    .lits      (in_q),
    .true_mask (cfg_true_mask),
    .comp_mask (cfg_comp_mask),
    .terms     (pt)
  );

  assign sum_or = pt[PT_SUM0] | pt[PT_SUM0+1] | pt[PT_SUM0+2];
  assign data_x = sum_or ^ pt[PT_XOR];

  plm_clock_sel u_clksel (
    .clk       (clk),
    .rst       (rst),
    .gclk_s    (gclk_q),
    .pt_clk    (pt[PT_CLK]),
    .use_pt    (cfg_clk_sel),
    .fall      (cfg_clk_fall),
    .clk_edge  (edge_w),
    .clk_level (level_w)
  );

  plm_storage u_store (
    .clk       (clk),
    .rst       (rst),
    .mode      (plm_mode_e'(cfg_mode)),
    .din       (data_x),
    .kr        (pt[PT_KR]),
    .pre       (pt[PT_PRE]),
    .clr       (pt[PT_CLR]),
    .clk_edge  (edge_w),
    .clk_level (level_w),
    .st        (state)
  );

  // align enable and pin sample with the stored value
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_d     <= 1'b0;
      pin_in_d <= 1'b0;
    end else begin
      oe_d     <= pt[PT_OE];
      pin_in_d <= pin_in_q;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_drive <= 1'b0;
      pin_oe    <= 1'b0;
      mc_fb     <= 1'b0;
      pin_fb    <= 1'b0;
    end else begin
      pin_drive <= state;
      pin_oe    <= oe_d;
      mc_fb     <= state;
      pin_fb    <= oe_d ? state : pin_in_d;
    end
  end

  // R12: an enabled pin reads back its own drive
  a_r12_pin_fb_driven: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> (pin_fb == pin_drive));
  // R11: cell feedback ignores the enable
  a_r11_mc_fb_matches: assert property (@(posedge clk) disable iff (rst)
    (mc_fb == pin_drive));
endmodule

// File: tb/plm_macrocell_tb.sv
`timescale 1ns/1ps
module plm_macrocell_tb_top;
  localparam int NI = 8;
  localparam int NT = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gclk_in = 1'b0;
  logic [NI-1:0] in_bus = '0;
  logic pin_in = 1'b0;
  logic [NT*NI-1:0] tmask = '0, cmask = '0;
  logic [2:0] mode = 3'd0;
  logic csel = 1'b0, cfall = 1'b0;
  logic pin_drive, pin_oe, mc_fb, pin_fb;

  int checks = 0;
  int errors = 0;
  int unsigned seed = 32'h1234_5679;

  typedef struct { bit st; bit oe; bit fb; } exp_t;
  exp_t q[$];
  bit m_st, m_prev;

  always #5 clk = ~clk;

  plm_macrocell #(.N_IN(NI)) dut_i (
    .clk(clk), .rst(rst), .gclk_in(gclk_in), .in_bus(in_bus), .pin_in(pin_in),
    .cfg_true_mask(tmask), .cfg_comp_mask(cmask), .cfg_mode(mode),
    .cfg_clk_sel(csel), .cfg_clk_fall(cfall),
    .pin_drive(pin_drive), .pin_oe(pin_oe), .mc_fb(mc_fb), .pin_fb(pin_fb)
  );

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // R1: literal semantics of a product term
  function automatic bit term(int t, logic [NI-1:0] v);
    for (int i = 0; i < NI; i++) begin
      if (tmask[t*NI+i] && !v[i]) return 1'b0;
      if (cmask[t*NI+i] &&  v[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // one system cycle of the behavioural reference
  function automatic exp_t model_step(logic [NI-1:0] v, bit g, bit pin);
    exp_t e;
    bit x, k, c, lvl, edg, pre, clr, inv;
    x   = (term(0, v) | term(1, v) | term(2, v)) ^ term(3, v);
    k   = term(4, v);
    pre = term(6, v);
    clr = term(7, v);
    c   = csel ? term(8, v) : g;
    inv = csel && cfall;
    lvl = inv ? !c : c;
    edg = inv ? (m_prev && !c) : (c && !m_prev);
    m_prev = c;
    if (mode == 3'd5) m_st = x;
    else if (clr) m_st = 1'b0;
    else if (pre) m_st = 1'b1;
    else if (mode == 3'd4) begin
      if (lvl) m_st = x;
    end else if (edg) begin
      case (mode)
        3'd1: m_st = m_st ^ x;
        3'd2: m_st = (x && k) ? !m_st : (x ? 1'b1 : (k ? 1'b0 : m_st));
        3'd3: m_st = (x && k) ? m_st : (x ? 1'b1 : (k ? 1'b0 : m_st));
        default: m_st = x;
      endcase
    end
    e.st = m_st;
    e.oe = term(5, v);
    e.fb = e.oe ? m_st : pin;
    return e;
  endfunction

  task automatic make_masks(bit xor_empty);
    tmask = '0;
    cmask = '0;
    for (int t = 0; t < NT; t++) begin
      int n;
      n = (t < 3) ? 1 + int'(rnd() % 2) : (t == 3) ? (xor_empty ? 0 : 1)
        : (t == 6 || t == 7) ? 3 : 1;
      for (int j = 0; j < n; j++) begin
        int idx;
        idx = int'(rnd() % NI);
        if (rnd() % 2 == 0) tmask[t*NI+idx] = 1'b1;
        else                cmask[t*NI+idx] = 1'b1;
      end
    end
  endtask

  task automatic check_bit(string tag, string what, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got=%0b expected=%0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic run_scen(bit [2:0] md, bit sel, bit fall, bit xor_empty,
                          bit prio, string tag, int ncyc);
    exp_t e;
    rst = 1'b1;
    mode = md; csel = sel; cfall = fall;
    make_masks(xor_empty);
    if (prio) begin
      // frequent preset/clear: term6 = in[0], term7 = in[1]
      tmask[6*NI +: NI] = 8'h01; cmask[6*NI +: NI] = 8'h00;
      tmask[7*NI +: NI] = 8'h02; cmask[7*NI +: NI] = 8'h00;
    end
    in_bus = '0; gclk_in = 1'b0; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R13", "reset pin_drive", pin_drive, 1'b0);
    check_bit("R13", "reset pin_oe", pin_oe, 1'b0);
    check_bit("R13", "reset mc_fb", mc_fb, 1'b0);
    check_bit("R13", "reset pin_fb", pin_fb, 1'b0);
    rst = 1'b0;
    q.delete();
    m_st = 1'b0;
    m_prev = 1'b0;
    q.push_back(model_step('0, 1'b0, 1'b0));
    for (int i = 0; i < ncyc; i++) begin
      logic [NI-1:0] v;
      bit g, p;
      if (q.size() == 3) begin
        e = q.pop_front();
        check_bit(tag, "pin_drive", pin_drive, e.st);
        check_bit(tag, "mc_fb", mc_fb, e.st);
        check_bit("R11", "pin_oe", pin_oe, e.oe);
        check_bit("R12", "pin_fb", pin_fb, e.fb);
      end
      v = NI'(rnd());
      g = rnd() % 2 == 1;
      p = rnd() % 2 == 1;
      in_bus = v; gclk_in = g; pin_in = p;
      q.push_back(model_step(v, g, p));
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R13 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string mt;
    @(negedge clk);
    for (int m = 0; m < 6; m++) begin
      for (int c = 0; c < 3; c++) begin
        case (m)
          0: mt = "R4";
          1: mt = "R5";
          2: mt = "R6";
          3: mt = "R7";
          4: mt = "R8";
          default: mt = "R3";
        endcase
        run_scen(3'(m), c != 0, c == 2, 1'b0, 1'b0,
                 {mt, " R10 R1 R2 R11"}, 300);
      end
    end
    run_scen(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 clear-over-preset", 300);
    run_scen(3'd4, 1'b1, 1'b1, 1'b0, 1'b1, "R9 R8 latch priority", 300);
    run_scen(3'd5, 1'b0, 1'b0, 1'b1, 1'b1, "R3 R1 R2 empty xor term", 300);
    run_scen(3'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R6 R10 inverted data", 300);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule